// File: doc/BRIEF.md
# Multi-size set-associative translation cache

This block holds recently used address translations for an I/O memory management unit. Each entry maps a 4 KiB, 64 KiB or 1 MiB page, and the entries sit in an array of 64 sets by 8 ways. A requester presents a virtual address on the lookup port and learns in the same cycle whether a translation is held and, if so, the physical address. When a lookup misses, an external page walker fetches the mapping and writes it in through the fill port.

All entries are indexed by virtual address bits [17:12], whatever their size. A 4 KiB page can therefore sit in only one set. A 64 KiB page lands in whichever of its 16 candidate sets the filling address selected, and a 1 MiB page can land in any set. Each way compares the tag under a mask that follows the page size it stores. Two maintenance commands remove entries. A flush empties the whole array. An address invalidate searches only the set its page number selects, so software has to issue one invalidate per candidate set to remove a large page for certain. If a lookup matches more than one way, the block reports a multi-hit fault on a separate signal for reads and for writes. The victim for a fill is the least recently used way when LRU is enabled, and a per-set round-robin pointer when it is not.

Top module: `tlbc_top`

## Requirements
- R1: After reset every entry is invalid. Every lookup then misses, with lk_hit, lk_mh_rd and lk_mh_wr all low.
- R2: A 4 KiB entry (fill_size 2'b00) is written into set fill_page[5:0]. A lookup whose address bits [31:12] equal the filled page hits, and lk_pa is {fill_ppn, lk_va[11:0]}.
- R3: A 64 KiB entry (fill_size 2'b01) goes into the set selected by fill_page[5:0] and matches on address bits [31:16]. A 1 MiB entry (fill_size 2'b10) goes into the same kind of set and matches on bits [31:20]. The low page-offset bits of lk_pa come from lk_va: [15:0] for 64 KiB and [19:0] for 1 MiB. A lookup that selects a different set misses, even inside the same page.
- R4: Lookup results are combinational in the lookup cycle and stay low while lk_valid is low. A fill is visible from the cycle after the clock edge that captures it, and not before.
- R5: An address invalidate (inv_en, inv_page) clears, at the next edge, every entry in set inv_page[5:0] that matches inv_page under its own size mask. Entries in other sets are untouched.
- R6: flush_all clears every valid entry at the next edge.
- R7: When two or more ways match, lk_hit stays low. lk_mh_rd is raised if lk_wr is 0, and lk_mh_wr if lk_wr is 1.
- R8: A fill takes the lowest-numbered invalid way of its set. If the set is full and lru_en is 1, it replaces the least recently used way. Both fills and lookup hits count as uses.
- R9: With lru_en at 0 and the set full, the victim is a per-set round-robin pointer. The pointer starts at way 0 after reset, steps once per such replacement and ignores lookups.
- R10: When commands coincide in one cycle, flush_all takes precedence over inv_en, which takes precedence over fill_en. The lower-priority command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lru_en | input | 1 | 1 selects LRU replacement, 0 selects round-robin |
| lk_valid | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is for a write access |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Exactly one way matched |
| lk_pa | output | 32 | Translated physical address |
| lk_mh_rd | output | 1 | Multi-hit fault on a read lookup |
| lk_mh_wr | output | 1 | Multi-hit fault on a write lookup |
| fill_en | input | 1 | Install a walker result |
| fill_page | input | 20 | Virtual page number (4 KiB units) of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_size | input | 2 | 00 = 4 KiB, 01 = 64 KiB, 10 = 1 MiB |
| flush_all | input | 1 | Clear all entries |
| inv_en | input | 1 | Invalidate by address |
| inv_page | input | 20 | Page number to invalidate |

## Verification
Lookup outputs are combinational, so the bench drives a lookup on the falling edge and samples it 1 ns later in the same cycle. The next rising edge never intervenes, so a check lookup does not count as a use for replacement unless the test asks for that. Fills, invalidates and flushes act on the following rising edge. Each check of their effect is therefore a lookup in the next low phase, and one test also shows that a fill is not yet visible in the cycle it is presented. Replacement order is checked by filling a set past its capacity and then probing which tags survive, with the expected survivors worked out from the LRU and round-robin rules.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  localparam int PG_SHIFT = 12;
  localparam logic [1:0] SZ_4K  = 2'b00;
  localparam logic [1:0] SZ_64K = 2'b01;
  localparam logic [1:0] SZ_1M  = 2'b10;

  // Page-number bits that take part in a compare for a given size.
  function automatic logic [31:0] keep_mask(input logic [1:0] sz);
    case (sz)
      SZ_64K:  keep_mask = ~32'h0000_000F;
      SZ_1M:   keep_mask = ~32'h0000_00FF;
      default: keep_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/tlbc_match.sv
module tlbc_match
  import tlbc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int VPN_W = 20
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][1:0]       sz,
  input  logic [WAYS-1:0][VPN_W-1:0] tag,
  input  logic [VPN_W-1:0]           vpn,
  output logic [WAYS-1:0]            hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] msk;
    assign msk    = VPN_W'(keep_mask(sz[w]));
    assign hit[w] = vld[w] && (((tag[w] ^ vpn) & msk) == '0);
  end
endmodule

// File: rtl/tlbc_repl.sv
module tlbc_repl #(
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lru_en,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic [$clog2(SETS)-1:0] sel_set,
  input  logic [WAYS-1:0]         sel_vld,
  input  logic                    fill_go,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAY_W-1:0]           rr_q  [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_nxt;
  logic [WAY_W-1:0]           ref_age;
  logic [WAY_W-1:0]           rr_nxt;
  logic                       rr_step;

  // Age update: touched way becomes youngest, younger ways age by one.
  always_comb begin
    ref_age = age_q[touch_set][touch_way];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)               age_nxt[w] = '0;
      else if (age_q[touch_set][w] < ref_age)   age_nxt[w] = age_q[touch_set][w] + 1'b1;
      else                                      age_nxt[w] = age_q[touch_set][w];
    end
  end

  always_comb begin
    victim = rr_q[sel_set];
    if (lru_en) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[sel_set][w] == OLDEST) victim = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!sel_vld[w]) victim = WAY_W'(w);
  end

  assign rr_step = fill_go && !lru_en && (&sel_vld);
  assign rr_nxt  = (rr_q[sel_set] == OLDEST) ? '0 : rr_q[sel_set] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (touch_en) age_q[touch_set] <= age_nxt;
      if (rr_step)  rr_q[sel_set]    <= rr_nxt;
    end
  end
endmodule

// File: rtl/tlbc_top.sv
module tlbc_top
  import tlbc_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lru_en,
  input  logic                     lk_valid,
  input  logic                     lk_wr,
  input  logic [VA_W-1:0]          lk_va,
  output logic                     lk_hit,
  output logic [PA_W-1:0]          lk_pa,
  output logic                     lk_mh_rd,
  output logic                     lk_mh_wr,
  input  logic                     fill_en,
  input  logic [VA_W-PG_SHIFT-1:0] fill_page,
  input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
  input  logic [1:0]               fill_size,
  input  logic                     flush_all,
  input  logic                     inv_en,
  input  logic [VA_W-PG_SHIFT-1:0] inv_page
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][1:0]       sz_q  [SETS];
  logic [WAYS-1:0][VPN_W-1:0] vpn_q [SETS];
  logic [WAYS-1:0][PPN_W-1:0] ppn_q [SETS];

  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set, inv_set, fill_set;
  logic [WAYS-1:0]  lk_hits, inv_hits;
  logic [WAY_W-1:0] hit_way, victim;
  logic [PPN_W-1:0] pa_pn;
  logic             one_hit, multi, fill_go, inv_go, touch_en;

  assign lk_vpn   = lk_va[VA_W-1:PG_SHIFT];
  assign lk_set   = lk_va[PG_SHIFT +: SET_W];
  assign inv_set  = inv_page[SET_W-1:0];
  assign fill_set = fill_page[SET_W-1:0];

  tlbc_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_lk_match (
    .vld(vld_q[lk_set]), .sz(sz_q[lk_set]), .tag(vpn_q[lk_set]),
    .vpn(lk_vpn), .hit(lk_hits)
  );

  tlbc_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_inv_match (
    .vld(vld_q[inv_set]), .sz(sz_q[inv_set]), .tag(vpn_q[inv_set]),
    .vpn(inv_page), .hit(inv_hits)
  );

  // Lookup result and translated page number
  always_comb begin
    hit_way = '0;
    pa_pn   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hits[w]) begin
        hit_way = WAY_W'(w);
        pa_pn   = pa_pn | (ppn_q[lk_set][w] & PPN_W'(keep_mask(sz_q[lk_set][w])))
                        | (PPN_W'(lk_vpn) & ~PPN_W'(keep_mask(sz_q[lk_set][w])));
      end
    end
  end

  assign one_hit  = ($countones(lk_hits) == 1);
  assign multi    = ($countones(lk_hits) > 1);
  assign lk_hit   = lk_valid && one_hit;
  assign lk_mh_rd = lk_valid && multi && !lk_wr;
  assign lk_mh_wr = lk_valid && multi && lk_wr;
  assign lk_pa    = {pa_pn, lk_va[PG_SHIFT-1:0]};

  // Command precedence: flush, then invalidate, then fill
  assign inv_go   = inv_en && !flush_all;
  assign fill_go  = fill_en && !flush_all && !inv_en;
  assign touch_en = fill_go || (!flush_all && !inv_en && lk_hit);

  tlbc_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
    .clk(clk), .rst_n(rst_n), .lru_en(lru_en),
    .touch_en(touch_en),
    .touch_set(fill_go ? fill_set : lk_set),
    .touch_way(fill_go ? victim : hit_way),
    .sel_set(fill_set), .sel_vld(vld_q[fill_set]),
    .fill_go(fill_go), .victim(victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (inv_go) begin
      vld_q[inv_set] <= vld_q[inv_set] & ~inv_hits;
    end else if (fill_go) begin
      vld_q[fill_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      sz_q[fill_set][victim]  <= fill_size;
      vpn_q[fill_set][victim] <= fill_page;
      ppn_q[fill_set][victim] <= fill_ppn;
    end
  end
endmodule

// File: rtl/tlbc_checker.sv
module tlbc_checker #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_wr,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_hit,
  input logic            lk_mh_rd,
  input logic            lk_mh_wr,
  input logic            fill_en,
  input logic [VA_W-13:0] fill_page,
  input logic            flush_all,
  input logic            inv_en,
  input logic [VA_W-13:0] inv_page
);
  p_hit_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !(lk_mh_rd || lk_mh_wr));

  p_mh_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_mh_rd |-> !lk_wr) and (lk_mh_wr |-> lk_wr));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_mh_rd || lk_mh_wr));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !(lk_hit || lk_mh_rd || lk_mh_wr));

  p_fill_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_en && !flush_all && !inv_en)
     && lk_va[VA_W-1:12] == $past(fill_page)) |-> (lk_hit || lk_mh_rd || lk_mh_wr));

  p_inv_gone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(inv_en && !flush_all)
     && lk_va[VA_W-1:12] == $past(inv_page)) |-> !(lk_hit || lk_mh_rd || lk_mh_wr));
endmodule

bind tlbc_top tlbc_checker #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_wr(lk_wr), .lk_va(lk_va),
  .lk_hit(lk_hit), .lk_mh_rd(lk_mh_rd), .lk_mh_wr(lk_mh_wr),
  .fill_en(fill_en), .fill_page(fill_page), .flush_all(flush_all),
  .inv_en(inv_en), .inv_page(inv_page)
);

// File: tb/sim_tlbc_top.sv
`timescale 1ns/1ps
module sim_tlbc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lru_en, lk_valid, lk_wr, lk_hit, lk_mh_rd, lk_mh_wr;
  logic [31:0] lk_va, lk_pa;
  logic        fill_en, flush_all, inv_en;
  logic [19:0] fill_page, fill_ppn, inv_page;
  logic [1:0]  fill_size;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tlbc_top u0 (
    .clk(clk), .rst_n(rst_n), .lru_en(lru_en), .lk_valid(lk_valid), .lk_wr(lk_wr),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_mh_rd(lk_mh_rd),
    .lk_mh_wr(lk_mh_wr), .fill_en(fill_en), .fill_page(fill_page),
    .fill_ppn(fill_ppn), .fill_size(fill_size), .flush_all(flush_all),
    .inv_en(inv_en), .inv_page(inv_page)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xl(input logic [31:0] va, input logic [19:0] ppn,
                                     input logic [1:0] sz);
    case (sz)
      2'b01:   xl = {ppn[19:4], va[15:0]};
      2'b10:   xl = {ppn[19:8], va[19:0]};
      default: xl = {ppn, va[11:0]};
    endcase
  endfunction

  // Lookup: result sampled in the same low phase; keep=1 lets it reach an edge.
  task automatic look(input logic [31:0] va, input logic wr, input logic keep,
                      input logic [2:0] e_res, input logic [31:0] e_pa, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_wr = wr; lk_va = va;
    #1;
    chk(req, {29'd0, lk_hit, lk_mh_rd, lk_mh_wr}, {29'd0, e_res});
    if (e_res == 3'b100) chk(req, lk_pa, e_pa);
    if (keep) begin
      @(posedge clk); #1;
    end
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic [1:0] sz);
    @(negedge clk);
    fill_en = 1'b1; fill_page = va[31:12]; fill_ppn = ppn; fill_size = sz;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inval(input logic [31:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_page = va[31:12];
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  function automatic logic [31:0] lru_va(input int t);
    lru_va = {14'(t + 1), 6'd0, 12'h0};
  endfunction
  function automatic logic [31:0] rr_va(input int t);
    rr_va = {14'(t + 40), 6'd1, 12'h0};
  endfunction
  function automatic logic [31:0] sw_va(input int s);
    sw_va = {14'(s * 37 + 5), 6'(s), 12'h0};
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lru_en = 1'b1; lk_valid = 1'b0; lk_wr = 1'b0; lk_va = '0;
    fill_en = 1'b0; fill_page = '0; fill_ppn = '0; fill_size = '0;
    flush_all = 1'b0; inv_en = 1'b0; inv_page = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(32'h1234_5678, 1'b0, 1'b0, 3'b000, '0, "R1");
    look(32'h0000_0000, 1'b1, 1'b0, 3'b000, '0, "R1");

    // R4: fill not visible in its own cycle, visible after the edge
    @(negedge clk);
    fill_en = 1'b1; fill_page = 20'h12345; fill_ppn = 20'hABCDE; fill_size = 2'b00;
    lk_valid = 1'b1; lk_wr = 1'b0; lk_va = 32'h1234_57FF;
    #1;
    chk("R4", {31'd0, lk_hit}, 32'd0);
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    look(32'h1234_57FF, 1'b0, 1'b0, 3'b100, 32'hABCD_E7FF, "R4");
    // R2: 4 KiB neighbours miss
    look(32'h1234_6000, 1'b0, 1'b0, 3'b000, '0, "R2");
    look(32'h1238_5000, 1'b0, 1'b0, 3'b000, '0, "R2");
    look(32'h1234_5000, 1'b1, 1'b0, 3'b100, 32'hABCD_E000, "R2");

    // R3: 64 KiB page placed in the set of its fill address
    fill(32'hABCD_5000, 20'h76543, 2'b01);
    look(32'hABCD_5123, 1'b0, 1'b0, 3'b100, xl(32'hABCD_5123, 20'h76543, 2'b01), "R3");
    look(32'hABCD_6000, 1'b0, 1'b0, 3'b000, '0, "R3");
    // R3: 1 MiB page, two addresses in the same set
    fill(32'h3C13_7000, 20'h9A5F0, 2'b10);
    look(32'h3C13_7456, 1'b0, 1'b0, 3'b100, xl(32'h3C13_7456, 20'h9A5F0, 2'b10), "R3");
    look(32'h3C17_7ABC, 1'b0, 1'b0, 3'b100, xl(32'h3C17_7ABC, 20'h9A5F0, 2'b10), "R3");
    look(32'h3C23_7000, 1'b0, 1'b0, 3'b000, '0, "R3");

    // R5: invalidate in another set of the 64 KiB page leaves it
    inval(32'hABCD_6000);
    look(32'hABCD_5000, 1'b0, 1'b0, 3'b100, xl(32'hABCD_5000, 20'h76543, 2'b01), "R5");
    inval(32'hABCD_5FFF);
    look(32'hABCD_5000, 1'b0, 1'b0, 3'b000, '0, "R5");
    look(32'h1234_5000, 1'b0, 1'b0, 3'b100, 32'hABCD_E000, "R5");

    // R7: overlapping 4 KiB and 64 KiB entries
    fill(32'h0055_2000, 20'h11111, 2'b00);
    fill(32'h0055_2000, 20'h22220, 2'b01);
    look(32'h0055_2010, 1'b0, 1'b0, 3'b010, '0, "R7");
    look(32'h0055_2010, 1'b1, 1'b0, 3'b001, '0, "R7");
    inval(32'h0055_2000);
    look(32'h0055_2010, 1'b0, 1'b0, 3'b000, '0, "R5");

    // R6: flush clears everything
    flush();
    look(32'h1234_5000, 1'b0, 1'b0, 3'b000, '0, "R6");
    look(32'h3C13_7000, 1'b0, 1'b0, 3'b000, '0, "R6");

    // R8: LRU in set 0
    lru_en = 1'b1;
    for (int t = 0; t < 8; t++) fill(lru_va(t), 20'(t + 16), 2'b00);
    look(lru_va(0), 1'b0, 1'b1, 3'b100, {20'd16, 12'h0}, "R8");
    fill(lru_va(8), 20'd99, 2'b00);
    look(lru_va(1), 1'b0, 1'b0, 3'b000, '0, "R8");
    look(lru_va(0), 1'b0, 1'b0, 3'b100, {20'd16, 12'h0}, "R8");
    look(lru_va(8), 1'b0, 1'b0, 3'b100, {20'd99, 12'h0}, "R8");
    look(lru_va(2), 1'b0, 1'b0, 3'b100, {20'd18, 12'h0}, "R8");

    // R9: round-robin in set 1, lookups do not matter
    lru_en = 1'b0;
    for (int t = 0; t < 8; t++) fill(rr_va(t), 20'(t + 200), 2'b00);
    look(rr_va(0), 1'b0, 1'b1, 3'b100, {20'd200, 12'h0}, "R9");
    fill(rr_va(8), 20'd300, 2'b00);
    fill(rr_va(9), 20'd301, 2'b00);
    look(rr_va(0), 1'b0, 1'b0, 3'b000, '0, "R9");
    look(rr_va(1), 1'b0, 1'b0, 3'b000, '0, "R9");
    look(rr_va(2), 1'b0, 1'b0, 3'b100, {20'd202, 12'h0}, "R9");
    look(rr_va(9), 1'b0, 1'b0, 3'b100, {20'd301, 12'h0}, "R9");
    lru_en = 1'b1;

    // R10: flush beats fill; invalidate beats fill
    @(negedge clk);
    flush_all = 1'b1; fill_en = 1'b1; fill_page = 20'h0F00F; fill_ppn = 20'h1; fill_size = 2'b00;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    look(32'h0F00_F000, 1'b0, 1'b0, 3'b000, '0, "R10");
    look(lru_va(0), 1'b0, 1'b0, 3'b000, '0, "R10");
    @(negedge clk);
    inv_en = 1'b1; inv_page = 20'h00001; fill_en = 1'b1;
    @(negedge clk);
    inv_en = 1'b0; fill_en = 1'b0;
    look(32'h0F00_F000, 1'b0, 1'b0, 3'b000, '0, "R10");

    // R2/R5/R6: sweep over every set
    for (int s = 0; s < 64; s++) fill(sw_va(s), 20'(s * 977 + 3), 2'b00);
    for (int s = 0; s < 64; s++)
      look(sw_va(s) | 32'h0000_0ABC, 1'b0, 1'b0, 3'b100,
           {20'(s * 977 + 3), 12'hABC}, "R2");
    for (int s = 1; s < 64; s += 2) inval(sw_va(s));
    for (int s = 0; s < 64; s++)
      look(sw_va(s), 1'b0, 1'b0, (s % 2 == 0) ? 3'b100 : 3'b000,
           {20'(s * 977 + 3), 12'h0}, "R5");
    flush();
    for (int s = 0; s < 64; s++) look(sw_va(s), 1'b1, 1'b0, 3'b000, '0, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule